// File: doc/BRIEF.md
# Prescaled Periodic Interval Timer

This block is a timer peripheral that raises an interrupt request at a fixed, programmable rate. Software sets it up through a small synchronous register port with three registers. The scale register sets a clock divider. The count register is the live down-counter. The period register holds the value the count returns to after each expiry. When the enable input is high, a prescaler divides the core clock by (scale + 1). Each prescaler tick moves the count one step toward zero. A tick that finds the count already at zero loads it from the period register and pulses the interrupt line for one clock.

A typical setup writes the scale, the period and an initial count while the timer is disabled, then raises the enable. The first interrupt comes (count + 1) * (scale + 1) enabled cycles after the enable rises. After that, interrupts repeat every (period + 1) * (scale + 1) enabled cycles. Software can read or rewrite the count at any time.

Top module: `interval_timer`

## Requirements
- R1: After reset the scale, count and period registers read zero and the interrupt output is low.
- R2: The register port uses a 2-bit address: 0 selects scale (8 bits, upper read-data bits zero), 1 selects count, 2 selects period, and 3 reads zero and ignores writes. Read data follows the address in the same cycle, and a write takes effect at the clock edge that samples it.
- R3: While enabled, the prescaler produces one tick every (scale + 1) enabled cycles. It restarts when the enable rises, so the first tick falls on the (scale + 1)-th enabled cycle.
- R4: On a tick, a nonzero count decrements by one, and a zero count is loaded with the period register's value.
- R5: The interrupt output is high for exactly the one cycle in which the count shows the reloaded period value. The first interrupt follows the enable by (count + 1) * (scale + 1) cycles, and later ones repeat every (period + 1) * (scale + 1) cycles.
- R6: A count write at the same edge as a tick wins. The count takes the written value, and no reload and no interrupt occur.
- R7: While the enable is low, the count holds its value and no interrupt is raised.
- R8: A scale value of 255 gives exactly 256 enabled cycles per count step.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en | input | 1 | Counting enable |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register select |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for the selected register |
| irq | output | 1 | One-cycle interrupt request at reload |

## Verification
The bench uses the default widths: an 8-bit scale and a 16-bit count and period. With an 8-bit scale, the largest divider (256) can be run to completion. The bench measures two full reload intervals at that divider in well under a thousand cycles. It keeps the counts and periods small so that intervals can be counted edge by edge, and it compares each measured interval against the (count + 1) * (scale + 1) and (period + 1) * (scale + 1) formulas.

// File: rtl/interval_timer_pkg.sv
// Shared definitions for the interval timer.
// Assumes a 2-bit register address on the register port.
package interval_timer_pkg;
    typedef enum logic [1:0] {
        SEL_SCALE  = 2'd0,
        SEL_COUNT  = 2'd1,
        SEL_PERIOD = 2'd2,
        SEL_NONE   = 2'd3
    } reg_sel_e;
endpackage

// File: rtl/interval_timer_regs.sv
// Register file: holds scale and period, decodes the count write strobe and
// drives the combinational read mux. Assumes SCALE_W <= DATA_W.
module interval_timer_regs
    import interval_timer_pkg::*;
#(
    parameter int SCALE_W = 8,
    parameter int DATA_W  = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [1:0]         addr,
    input  logic [DATA_W-1:0]  wdata,
    input  logic [DATA_W-1:0]  count_val,
    output logic [SCALE_W-1:0] scale_q,
    output logic [DATA_W-1:0]  period_q,
    output logic               count_wr,
    output logic [DATA_W-1:0]  rdata
);
    reg_sel_e sel;
    assign sel = reg_sel_e'(addr);

    // Decode the count write strobe for the down-counter.
    always_comb count_wr = wr_en && (sel == SEL_COUNT);

    // Store scale and period on writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scale_q  <= '0;
            period_q <= '0;
        end else if (wr_en) begin
            if (sel == SEL_SCALE)  scale_q  <= wdata[SCALE_W-1:0];
            if (sel == SEL_PERIOD) period_q <= wdata;
        end
    end

    // Select the read data from the addressed register.
    always_comb begin
        case (sel)
            SEL_SCALE:  rdata = DATA_W'(scale_q);
            SEL_COUNT:  rdata = count_val;
            SEL_PERIOD: rdata = period_q;
            default:    rdata = '0;
        endcase
    end
endmodule

// File: rtl/interval_timer_prescaler.sv
// Prescaler: emits one tick every (scale+1) enabled cycles. Restarts on a
// rising enable and holds its state while disabled.
module interval_timer_prescaler #(
    parameter int SCALE_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               en,
    input  logic [SCALE_W-1:0] scale,
    output logic               tick
);
    logic [SCALE_W-1:0] remain_q;
    logic               en_q;
    logic               start;

    // A rising enable starts a fresh division period.
    always_comb start = en && !en_q;

    // Tick when the remaining-cycle count is exhausted.
    always_comb tick = en && (start ? (scale == '0) : (remain_q == '0));

    // Advance, reload or restart the remaining-cycle counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remain_q <= '0;
            en_q     <= 1'b0;
        end else begin
            en_q <= en;
            if (tick)       remain_q <= scale;
            else if (start) remain_q <= scale - 1'b1;
            else if (en)    remain_q <= remain_q - 1'b1;
        end
    end
endmodule

// File: rtl/interval_timer_downcount.sv
// Down-counter with period reload and a one-cycle interrupt pulse.
// Assumes tick is low whenever the timer is disabled.
module interval_timer_downcount #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic [CNT_W-1:0] period,
    output logic [CNT_W-1:0] count_q,
    output logic             irq_q
);
    logic wrap;

    // A tick on a zero count triggers a reload.
    always_comb wrap = tick && (count_q == '0);

    // Update the count; a software load has the highest priority.
    always_ff @(posedge clk) begin
        if (!rst_n)     count_q <= '0;
        else if (load)  count_q <= load_val;
        else if (wrap)  count_q <= period;
        else if (tick)  count_q <= count_q - 1'b1;
    end

    // Pulse the interrupt in the cycle the reloaded value appears.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= wrap && !load;
    end
endmodule

// File: rtl/interval_timer.sv
// Top of the prescaled periodic interval timer: ties together the register
// file, prescaler and down-counter. Data width equals the count width.
module interval_timer #(
    parameter int SCALE_W = 8,
    parameter int CNT_W   = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             wr_en,
    input  logic [1:0]       addr,
    input  logic [CNT_W-1:0] wdata,
    output logic [CNT_W-1:0] rdata,
    output logic             irq
);
    localparam int DATA_W = CNT_W;

    logic [SCALE_W-1:0] scale_q;
    logic [CNT_W-1:0]   period_q;
    logic [CNT_W-1:0]   count_q;
    logic               count_wr;
    logic               tick;

    interval_timer_regs #(.SCALE_W(SCALE_W), .DATA_W(DATA_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .count_val(count_q), .scale_q(scale_q), .period_q(period_q),
        .count_wr(count_wr), .rdata(rdata)
    );

    interval_timer_prescaler #(.SCALE_W(SCALE_W)) u_pre (
        .clk(clk), .rst_n(rst_n), .en(en), .scale(scale_q), .tick(tick)
    );

    interval_timer_downcount #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .tick(tick), .load(count_wr),
        .load_val(wdata), .period(period_q), .count_q(count_q), .irq_q(irq)
    );
endmodule

// File: rtl/interval_timer_checker.sv
// Temporal checks on the interval timer, bound to every instance of it.
module interval_timer_checker #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             en,
    input logic             wr_en,
    input logic [1:0]       addr,
    input logic [CNT_W-1:0] wdata,
    input logic             irq,
    input logic [CNT_W-1:0] count_q,
    input logic [CNT_W-1:0] period_q,
    input logic             tick
);
    // R7: no interrupt unless the previous cycle was enabled.
    assert_irq_needs_en_R7: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $past(en));

    // R7: disabled and not written, the count holds.
    assert_hold_when_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !(wr_en && addr == 2'd1)) |=> (count_q == $past(count_q)));

    // R6: a count write wins and suppresses the interrupt.
    assert_write_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 2'd1) |=> (count_q == $past(wdata) && !irq));

    // R5: the interrupt coincides with the reloaded period value.
    assert_irq_reload_R5: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (count_q == $past(period_q)));

    // R4: a tick on a nonzero count decrements it.
    assert_decrement_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && count_q != '0 && !(wr_en && addr == 2'd1))
        |=> (count_q == $past(count_q) - 1'b1));
endmodule

bind interval_timer interval_timer_checker #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .en(en), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .irq(irq), .count_q(count_q), .period_q(period_q),
    .tick(tick)
);

// File: tb/interval_timer_test.sv
module interval_timer_test;
    localparam int CLK_NS = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  addr = 2'd0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic        irq;

    int checks = 0;
    int failures = 0;

    interval_timer uut (
        .clk(clk), .rst_n(rst_n), .en(en), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .irq(irq)
    );

    always #(CLK_NS/2) clk = ~clk;

    initial begin
        #(CLK_NS * 200000);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic reg_write(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic reg_read(input logic [1:0] a, output int v);
        @(negedge clk);
        addr = a;
        #1;
        v = int'(rdata);
    endtask

    task automatic count_to_irq(input int limit, output int n);
        n = 0;
        do begin
            @(posedge clk); #1; n++;
        end while (!irq && n < limit);
    endtask

    task automatic setup(input int s, input int c, input int p);
        @(negedge clk); en = 1'b0;
        reg_write(2'd0, 16'(s));
        reg_write(2'd2, 16'(p));
        reg_write(2'd1, 16'(c));
        addr = 2'd1;
    endtask

    task automatic t_reset();
        int v;
        reg_read(2'd0, v); check("R1 scale", v, 0);
        reg_read(2'd1, v); check("R1 count", v, 0);
        reg_read(2'd2, v); check("R1 period", v, 0);
        check("R1 irq", int'(irq), 0);
    endtask

    task automatic t_regs();
        int v;
        reg_write(2'd0, 16'hAB5A);
        reg_write(2'd2, 16'hBEEF);
        reg_write(2'd1, 16'h1234);
        reg_write(2'd3, 16'hFFFF);
        reg_read(2'd0, v); check("R2 scale low byte", v, 16'h005A);
        reg_read(2'd2, v); check("R2 period", v, 16'hBEEF);
        reg_read(2'd1, v); check("R2 count", v, 16'h1234);
        reg_read(2'd3, v); check("R2 unused addr", v, 0);
    endtask

    task automatic t_basic();
        int n;
        setup(0, 2, 3);
        @(negedge clk); en = 1'b1;
        count_to_irq(100, n);
        check("R5 first interval s0", n, 3);
        check("R4 reload value", int'(rdata), 3);
        @(posedge clk); #1;
        check("R5 pulse width", int'(irq), 0);
        count_to_irq(100, n);
        check("R5 repeat interval s0", n, 3);
        @(negedge clk); en = 1'b0;
    endtask

    task automatic t_prescaled();
        int n;
        setup(2, 1, 2);
        @(negedge clk); en = 1'b1;
        count_to_irq(200, n);
        check("R3 first interval s2", n, 6);
        count_to_irq(200, n);
        check("R3 repeat interval s2", n, 9);
        @(negedge clk); en = 1'b0;
    endtask

    task automatic t_scale_max();
        int n;
        setup(255, 0, 1);
        @(negedge clk); en = 1'b1;
        count_to_irq(2000, n);
        check("R8 first interval s255", n, 256);
        count_to_irq(2000, n);
        check("R8 repeat interval s255", n, 512);
        @(negedge clk); en = 1'b0;
    endtask

    task automatic t_hold();
        int seen = 0;
        setup(0, 10, 50);
        @(negedge clk); en = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk); en = 1'b0;
        repeat (5) begin
            @(posedge clk); #1;
            if (irq) seen++;
        end
        check("R7 count held", int'(rdata), 7);
        check("R7 no irq when off", seen, 0);
    endtask

    task automatic t_restart();
        setup(3, 5, 50);
        @(negedge clk); en = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk); en = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk); en = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        check("R3 restart no early tick", int'(rdata), 5);
        @(posedge clk); #1;
        check("R3 restart tick on 4th", int'(rdata), 4);
        @(negedge clk); en = 1'b0;
    endtask

    task automatic t_write_priority();
        setup(0, 0, 9);
        @(negedge clk);
        en = 1'b1; wr_en = 1'b1; addr = 2'd1; wdata = 16'd6;
        @(posedge clk); #1;
        check("R6 write beats reload", int'(rdata), 6);
        check("R6 no irq on write", int'(irq), 0);
        @(negedge clk); wdata = 16'd20;
        @(posedge clk); #1;
        check("R6 write beats decrement", int'(rdata), 20);
        @(negedge clk); wr_en = 1'b0; en = 1'b0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        t_reset();
        t_regs();
        t_basic();
        t_prescaled();
        t_scale_max();
        t_hold();
        t_restart();
        t_write_priority();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule